// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block performs the bus transactions a processor core needs when it enters a hardware interrupt or comes out of reset. The core offers an entry request over a valid/ready handshake. The request carries the kind of interrupt and a snapshot of the core's state: the return address, the stack pointer, the stack mode and the status byte. The block then spends three cycles writing to the stack: the return address high byte, then the low byte, then the status byte with its break bit cleared. After that it spends two cycles reading the new program counter from the vector for that kind of interrupt. The updated program counter, stack pointer and status byte are returned on output ports, and a one-cycle done pulse tells the core that fetching may resume.

Reset works differently. Pulling `rst_n` low aborts any sequence in progress at once. It also loads the reset state: B and Z cleared, stack in byte mode on page 1, and the status byte with its E and I bits set. The release of reset is synchronised. After that comes a fixed number of idle cycles, and then the reset vector is fetched. Reset makes no stack writes. The request handshake follows these rules. `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the core must hold the payload stable. The memory bus has no back-pressure: a write completes in the cycle it is presented, and read data returns one cycle after the address.

Top module: `irq_entry_seq`

## Requirements
- R1: `req_ready` is high only while `busy` is low. When a request is accepted, the first stack write is presented in the next cycle, and `busy` is high from that cycle until the sequence ends.
- R2: Interrupt entry makes exactly three writes, on consecutive cycles, to descending stack addresses: return address bits [15:8], then bits [7:0], then the status byte. Write and read are never asserted together.
- R3: The pushed return address equals `req_pc` exactly as supplied.
- R4: The pushed status byte equals `req_status` with bit 4 (break) forced to 0.
- R5: In byte stack mode (`req_sp_word`=0), each write address is {`req_sp[15:8]`, pointer}, where the 8-bit pointer starts at `req_sp[7:0]` and wraps within the page. The final `sp_o` is {page, pointer-3 mod 256}.
- R6: In word stack mode (`req_sp_word`=1), the write addresses are `req_sp`, `req_sp`-1 and `req_sp`-2 as 16-bit values, and the final `sp_o` is `req_sp`-3.
- R7: After the writes come two reads on consecutive cycles, the low byte from the even vector address and the high byte from the next address. The vector is 0xFFFE when `req_nmi`=0 and 0xFFFA when `req_nmi`=1.
- R8: Once the entry completes, `status_o` equals `req_status` with bit 2 (interrupt disable) set. Bit 2 is already set whenever a vector read is on the bus.
- R9: `done` is a single-cycle pulse in the cycle after the high vector byte is returned. In that cycle `busy` is low and `pc_o` holds {high byte, low byte}.
- R10: While `rst_n` is low, there is no bus activity, `busy` is 1, `req_ready` is 0, `b_o`=0, `z_o`=0, `sp_word_o`=0, `sp_o`=0x01FF and `status_o`=0x24 (bits 5 and 2 set).
- R11: After `rst_n` rises, the first read of 0xFFFC appears exactly 6 rising edges later (2 synchroniser stages plus 4 idle cycles). A read of 0xFFFD follows, then `done` with `pc_o` loaded. No writes occur during this sequence.
- R12: Asserting `rst_n` in the middle of an entry stops its writes at once. Later resets and entries run normally.
- R13: When `ld_bz`=1 at a clock edge, `b_o` and `z_o` take `ld_b` and `ld_z`. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| req_valid | input | 1 | Entry request offered |
| req_ready | output | 1 | Entry request can be taken |
| req_nmi | input | 1 | 1 selects the non-maskable vector, 0 the maskable one |
| req_pc | input | 16 | Return address to push |
| req_sp | input | 16 | Stack pointer at entry |
| req_sp_word | input | 1 | 1 = 16-bit stack, 0 = byte stack within page |
| req_status | input | 8 | Status byte at entry |
| ld_bz | input | 1 | Load strobe for the B and Z registers |
| ld_b | input | 8 | New B value |
| ld_z | input | 8 | New Z value |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Bus write strobe |
| mem_re | output | 1 | Bus read strobe |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| sp_word_o | output | 1 | Stack mode |
| status_o | output | 8 | Status byte |
| b_o | output | 8 | B register |
| z_o | output | 8 | Z register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Fetch may resume at `pc_o` |

## Verification
A wrong sequencer state shows up on the bus within one cycle. The bus would show a write where a read belongs, a missing or extra transaction, or a change in the spacing the bench counts from acceptance or from reset release. A wrong stack pointer or mode shows up on the next write as a wrong address, and at the end as a wrong `sp_o`. A wrong vector kind shows up on the first read address. A miscaptured byte shows up in `pc_o` in the `done` cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_H,
    S_PUSH_L,
    S_PUSH_P,
    S_VEC_LO,
    S_VEC_HI,
    S_VEC_END,
    S_RST_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    K_IRQ,
    K_NMI,
    K_RST
  } entry_kind_t;

  // status byte bit positions
  localparam int ST_BRK   = 4;
  localparam int ST_IMASK = 2;
  localparam int ST_EXT   = 5;

  // vector offset relative to the lowest (non-maskable) vector
  function automatic int vec_offset(input entry_kind_t k);
    case (k)
      K_NMI:   return 0;
      K_RST:   return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rel
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rel = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign rel = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/stack_agu.sv
module stack_agu #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] sp,
  input  logic            word_mode,
  output logic [2*DW-1:0] addr,
  output logic [2*DW-1:0] sp_next
);

  localparam int AW = 2 * DW;

  assign addr = sp;

  always_comb begin
    if (word_mode) sp_next = sp - AW'(1);
    else           sp_next = {sp[AW-1:DW], sp[DW-1:0] - DW'(1)};
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int IDLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rel,
  input  logic       req_fire,
  output seq_state_t state,
  output logic       done
);

  localparam int CW = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC + 1);

  logic [CW-1:0] cnt;
  seq_state_t    nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_RST_WAIT: if (rel && cnt == CW'(IDLE_CYC - 1)) nxt = S_VEC_LO;
      S_IDLE:     if (req_fire) nxt = S_PUSH_H;
      S_PUSH_H:   nxt = S_PUSH_L;
      S_PUSH_L:   nxt = S_PUSH_P;
      S_PUSH_P:   nxt = S_VEC_LO;
      S_VEC_LO:   nxt = S_VEC_HI;
      S_VEC_HI:   nxt = S_VEC_END;
      S_VEC_END:  nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RST_WAIT;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == S_VEC_END);
      if (state == S_RST_WAIT && rel) cnt <= cnt + CW'(1);
      else                            cnt <= '0;
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          DW          = 8,
  parameter logic [15:0] VEC_NMI     = 16'hFFFA,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_IDLE    = 4,
  parameter logic [7:0]  SP_PAGE_RST = 8'h01,
  parameter logic [7:0]  SP_PTR_RST  = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_nmi,
  input  logic [2*DW-1:0] req_pc,
  input  logic [2*DW-1:0] req_sp,
  input  logic            req_sp_word,
  input  logic [DW-1:0]   req_status,
  input  logic            ld_bz,
  input  logic [DW-1:0]   ld_b,
  input  logic [DW-1:0]   ld_z,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] pc_o,
  output logic [2*DW-1:0] sp_o,
  output logic            sp_word_o,
  output logic [DW-1:0]   status_o,
  output logic [DW-1:0]   b_o,
  output logic [DW-1:0]   z_o,
  output logic            busy,
  output logic            done
);

  localparam int          AW         = 2 * DW;
  localparam logic [DW-1:0] STATUS_RST = DW'((1 << ST_EXT) | (1 << ST_IMASK));
  localparam logic [DW-1:0] BRK_MASK   = ~DW'(1 << ST_BRK);

  seq_state_t    state;
  entry_kind_t   kind_q;
  logic          rel;
  logic          req_fire;
  logic [AW-1:0] pc_q, sp_q, stk_addr, sp_next, vec_base;
  logic          sp_word_q;
  logic [DW-1:0] status_q, b_q, z_q;

  assign req_ready = (state == S_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign busy      = (state != S_IDLE);

  rst_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rel   (rel)
  );

  seq_ctrl #(.IDLE_CYC(RST_IDLE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel      (rel),
    .req_fire (req_fire),
    .state    (state),
    .done     (done)
  );

  stack_agu #(.DW(DW)) u_agu (
    .sp        (sp_q),
    .word_mode (sp_word_q),
    .addr      (stk_addr),
    .sp_next   (sp_next)
  );

  assign vec_base = AW'(VEC_NMI) + AW'(vec_offset(kind_q));

  // bus drive from sequencer state
  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_H: begin
        mem_we    = 1'b1;
        mem_addr  = stk_addr;
        mem_wdata = pc_q[AW-1:DW];
      end
      S_PUSH_L: begin
        mem_we    = 1'b1;
        mem_addr  = stk_addr;
        mem_wdata = pc_q[DW-1:0];
      end
      S_PUSH_P: begin
        mem_we    = 1'b1;
        mem_addr  = stk_addr;
        mem_wdata = status_q & BRK_MASK;
      end
      S_VEC_LO: begin
        mem_re   = 1'b1;
        mem_addr = vec_base;
      end
      S_VEC_HI: begin
        mem_re   = 1'b1;
        mem_addr = vec_base + AW'(1);
      end
      default: ;
    endcase
  end

  // architectural state held for the core
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      sp_q      <= {SP_PAGE_RST, SP_PTR_RST};
      sp_word_q <= 1'b0;
      status_q  <= STATUS_RST;
      b_q       <= '0;
      z_q       <= '0;
      kind_q    <= K_RST;
    end else begin
      if (ld_bz) begin
        b_q <= ld_b;
        z_q <= ld_z;
      end
      unique case (state)
        S_IDLE: if (req_fire) begin
          pc_q      <= req_pc;
          sp_q      <= req_sp;
          sp_word_q <= req_sp_word;
          status_q  <= req_status;
          kind_q    <= req_nmi ? K_NMI : K_IRQ;
        end
        S_PUSH_H, S_PUSH_L: sp_q <= sp_next;
        S_PUSH_P: begin
          sp_q               <= sp_next;
          status_q[ST_IMASK] <= 1'b1;
        end
        S_VEC_HI:  pc_q[DW-1:0]  <= mem_rdata;
        S_VEC_END: pc_q[AW-1:DW] <= mem_rdata;
        default: ;
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign sp_word_o = sp_word_q;
  assign status_o  = status_q;
  assign b_o       = b_q;
  assign z_o       = z_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2*DW-1:0] mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            mem_we,
  input logic            mem_re,
  input logic [DW-1:0]   status_o,
  input logic            sp_word_o,
  input logic            busy,
  input logic            done
);

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  // R1
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_we && busy));

  // R2
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R2
  push_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) - DW'(1)));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && !sp_word_o) |-> (mem_addr[2*DW-1:DW] == $past(mem_addr[2*DW-1:DW])));

  // R4
  brk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(mem_we, 2)) |-> !mem_wdata[4]);

  // R7
  vec_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re) |-> !mem_addr[0]);

  // R7
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + (2*DW)'(1)));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> status_o[2]);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .status_o  (status_o),
  .sp_word_o (sp_word_o),
  .busy      (busy),
  .done      (done)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_nmi = 1'b0;
  logic [15:0] req_pc = '0;
  logic [15:0] req_sp = '0;
  logic        req_sp_word = 1'b0;
  logic [7:0]  req_status = '0;
  logic        ld_bz = 1'b0;
  logic [7:0]  ld_b = '0;
  logic [7:0]  ld_z = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] pc_o, sp_o;
  logic        sp_word_o;
  logic [7:0]  status_o, b_o, z_o;
  logic        busy, done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_nmi(req_nmi), .req_pc(req_pc), .req_sp(req_sp), .req_sp_word(req_sp_word),
    .req_status(req_status), .ld_bz(ld_bz), .ld_b(ld_b), .ld_z(ld_z),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .pc_o(pc_o), .sp_o(sp_o), .sp_word_o(sp_word_o),
    .status_o(status_o), .b_o(b_o), .z_o(z_o), .busy(busy), .done(done)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h3C;
  endfunction

  // synchronous read memory, one cycle latency
  always @(posedge clk) mem_rdata <= memf(mem_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // one full entry; called at a negedge with the block idle
  task automatic run_entry(input logic nmi, input logic [15:0] pc, input logic [15:0] sp,
                           input logic word, input logic [7:0] st);
    logic [15:0] base, a0, a1, a2, sp_end, exp_pc;
    string mtag;
    base   = nmi ? 16'hFFFA : 16'hFFFE;
    exp_pc = {memf(base + 16'd1), memf(base)};
    mtag   = word ? "R6" : "R5";
    a0 = sp;
    a1 = word ? sp - 16'd1 : {sp[15:8], sp[7:0] - 8'd1};
    a2 = word ? sp - 16'd2 : {sp[15:8], sp[7:0] - 8'd2};
    sp_end = word ? sp - 16'd3 : {sp[15:8], sp[7:0] - 8'd3};
    req_nmi = nmi; req_pc = pc; req_sp = sp; req_sp_word = word; req_status = st;
    req_valid = 1'b1;
    #0.5;
    check("R1 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 busy after accept", busy, 1);
    check("R2 first write", {mem_we, mem_re}, 2'b10);
    check({mtag, " push addr 0"}, a0, mem_addr);
    check("R3 pc high pushed", mem_wdata, pc[15:8]);
    @(negedge clk);
    check("R2 second write", {mem_we, mem_re}, 2'b10);
    check({mtag, " push addr 1"}, mem_addr, a1);
    check("R3 pc low pushed", mem_wdata, pc[7:0]);
    @(negedge clk);
    check("R2 third write", {mem_we, mem_re}, 2'b10);
    check({mtag, " push addr 2"}, mem_addr, a2);
    check("R4 status pushed", mem_wdata, st & 8'hEF);
    @(negedge clk);
    check("R7 low read", {mem_we, mem_re}, 2'b01);
    check("R7 low vector addr", mem_addr, base);
    @(negedge clk);
    check("R7 high read", {mem_we, mem_re}, 2'b01);
    check("R7 high vector addr", mem_addr, base + 16'd1);
    @(negedge clk);
    check("R2 quiet bus", {mem_we, mem_re, busy, done}, 4'b0010);
    @(negedge clk);
    check("R9 done pulse", {done, busy}, 2'b10);
    check("R9 new pc", pc_o, exp_pc);
    check({mtag, " final sp"}, sp_o, sp_end);
    check("R8 status after", status_o, st | 8'h04);
    @(negedge clk);
    check("R9 done single", done, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 1);
    check("R10 ready", req_ready, 0);
    check("R10 bus idle", {mem_we, mem_re}, 2'b00);
    check("R10 b z", {b_o, z_o}, 16'h0000);
    check("R10 sp", sp_o, 16'h01FF);
    check("R10 sp mode", sp_word_o, 0);
    check("R10 status", status_o, 8'h24);

    // R11 release timing
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (mem_we) check("R11 no write", mem_we, 0);
    end while (!mem_re && n < 20);
    check("R11 edges to first read", n, 6);
    check("R11 reset low vector", mem_addr, 16'hFFFC);
    @(negedge clk);
    check("R11 reset high vector", {mem_re, mem_addr}, {1'b1, 16'hFFFD});
    @(negedge clk);
    @(negedge clk);
    check("R11 reset done", done, 1);
    check("R11 reset pc", pc_o, {memf(16'hFFFD), memf(16'hFFFC)});

    // R13 B/Z load
    ld_bz = 1'b1; ld_b = 8'h5A; ld_z = 8'hA5;
    @(negedge clk);
    ld_bz = 1'b0;
    check("R13 b z loaded", {b_o, z_o}, 16'h5AA5);

    // sweep: both modes, both kinds, every pointer low byte
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 2; v++)
        for (int k = 0; k < 256; k++)
          run_entry(v[0], 16'(k * 773 + 11), {8'(k * 37 + 5), 8'(k)}, m[0], 8'(k * 29 + 3));

    // R12 abort in the middle of an entry
    req_nmi = 1'b0; req_pc = 16'hBEEF; req_sp = 16'h3456; req_sp_word = 1'b1;
    req_status = 8'hFF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 writes stop", {mem_we, mem_re}, 2'b00);
    check("R10 busy in reset", {busy, req_ready}, 2'b10);
    check("R13 reset clears b z", {b_o, z_o}, 16'h0000);
    check("R10 sp after abort", {sp_word_o, sp_o}, {1'b0, 16'h01FF});
    check("R10 status after abort", status_o, 8'h24);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 30);
    check("R12 reset sequence completes", pc_o, {memf(16'hFFFD), memf(16'hFFFC)});
    @(negedge clk);
    run_entry(1'b1, 16'h1234, 16'h0100, 1'b0, 8'h10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule